// File: doc/BRIEF.md
# Dual-Line Left-Justified Audio Receiver

This block takes serial audio from two external converter data lines and rebuilds, for each line, a parallel 24-bit left sample and a parallel 24-bit right sample. Both lines share one bit clock and one frame clock. A run-time select input picks one of two clock pairs: the DAC-side pair or the ADC-side pair. The serial format is fixed. Samples are 24 bits long, sent most significant bit first and left-justified. It does not depend on any other serial-port setting.

All clocks, data lines and the select input are oversampled by the faster system clock. Each one passes through a two-flop synchronizer, and bit-clock rising edges are found by edge detection. A three-state machine follows the frame:

- **HUNT**: waiting for a frame start.
- **LEFT**: the frame clock is high and the left samples are being assembled.
- **RIGHT**: the frame clock is low and the right samples are being assembled.

The transitions are:

- **start** (HUNT to LEFT): on a frame-clock rise.
- **split** (LEFT to RIGHT): on a frame-clock fall.
- **wrap** (RIGHT to LEFT): on the next frame-clock rise, which also ends the frame.
- **abandon** (any state to HUNT): whenever the synchronized select value changes.

On **wrap**, a frame that held exactly 64 or exactly 128 bit clocks updates all four words at once, with a one-cycle valid pulse. Any other count raises a rate-error flag instead.

Top module: `lj_dual_rx`

## Requirements
- R1: While reset is asserted and right after its release, all four sample words read zero, `smp_valid` is low and `rate_err` is low.
- R2: `src_sel` = 1 times reception from `dac_bclk`/`dac_fclk`. `src_sel` = 0 times it from `adc_bclk`/`adc_fclk`. The pair that is not selected has no effect.
- R3: Each line's bit is sampled on a rising edge of the selected bit clock. The first rising edge after a frame-clock transition carries the MSB, and the next 23 rising edges carry the rest, MSB first.
- R4: Bits received while the frame clock is high form the left word. Bits received while it is low form the right word. A frame starts at a frame-clock rise, so the left half comes first.
- R5: Bits after the 24th in a half-frame are ignored. A frame of exactly 64 or exactly 128 bit clocks updates all four words together at the frame-clock rise that ends it, with `smp_valid` high for exactly one system cycle. The words do not change at any other time.
- R6: A frame whose bit-clock count is neither 64 nor 128 gives no valid pulse and leaves the words unchanged. It sets `rate_err`, which stays set until the next frame with a legal count clears it.
- R7: A change of the select value discards the frame in progress. Reception resumes at the next frame-clock rise of the newly selected pair.
- R8: A bit-clock rise that falls in the same system cycle as a frame-clock transition counts as the first bit of the new half and the new frame. When this happens at a frame end, the publication of the finished frame takes place in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than any bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 1 | Clock-pair select: 1 = DAC-side pair, 0 = ADC-side pair |
| dac_bclk | input | 1 | DAC-side bit clock |
| dac_fclk | input | 1 | DAC-side frame clock |
| adc_bclk | input | 1 | ADC-side bit clock |
| adc_fclk | input | 1 | ADC-side frame clock |
| sdata_a | input | 1 | Serial data, line A |
| sdata_b | input | 1 | Serial data, line B |
| left_a | output | 24 | Left sample of line A |
| right_a | output | 24 | Right sample of line A |
| left_b | output | 24 | Left sample of line B |
| right_b | output | 24 | Right sample of line B |
| smp_valid | output | 1 | One-cycle pulse when the four words update |
| rate_err | output | 1 | Set by a frame with an illegal bit-clock count |

## Verification
Two actions can fall in the same system cycle: closing and publishing the finished frame, and capturing the MSB of the next frame. The bench provokes this with frames that move the frame clock at the exact instant of a bit-clock rise, so that both edges leave the synchronizer together. In those frames the published words must still equal the sent frame. The next frame must then also be received intact, which is only possible if its MSB was counted at the frame boundary. The verdict is taken on the captured words and on the pulse and flag behaviour, for both 64 and 128 bit clocks and for both clock pairs.

// File: rtl/ljrx_pkg.sv
package ljrx_pkg;
    typedef enum logic [1:0] {
        S_HUNT  = 2'd0,
        S_LEFT  = 2'd1,
        S_RIGHT = 2'd2
    } fr_state_e;
endpackage

// File: rtl/ljrx_sync.sv
module ljrx_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_o    <= '0;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/ljrx_front.sv
module ljrx_front #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_s,
    input  logic             dac_bclk_s,
    input  logic             dac_fclk_s,
    input  logic             adc_bclk_s,
    input  logic             adc_fclk_s,
    input  logic [LANES-1:0] dat_s,
    output logic             bit_stb,
    output logic             fr_rise,
    output logic             fr_fall,
    output logic             sel_chg,
    output logic [LANES-1:0] bit_dat
);
    logic bclk_m, fclk_m;
    logic bclk_q, fclk_q, sel_q;

    // R2: pick the clock pair after synchronization
    always_comb begin
        if (sel_s) begin
            bclk_m = dac_bclk_s;
            fclk_m = dac_fclk_s;
        end else begin
            bclk_m = adc_bclk_s;
            fclk_m = adc_fclk_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            fclk_q <= 1'b0;
            sel_q  <= 1'b0;
        end else begin
            bclk_q <= bclk_m;
            fclk_q <= fclk_m;
            sel_q  <= sel_s;
        end
    end

    assign sel_chg = sel_s ^ sel_q;
    assign bit_stb = !sel_chg && bclk_m && !bclk_q;
    assign fr_rise = !sel_chg && fclk_m && !fclk_q;
    assign fr_fall = !sel_chg && !fclk_m && fclk_q;
    assign bit_dat = dat_s;
endmodule

// File: rtl/ljrx_frame.sv
module ljrx_frame
    import ljrx_pkg::*;
#(
    parameter int W      = 24,
    parameter int LANES  = 2,
    parameter int LO_BCK = 64,
    parameter int HI_BCK = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bit_stb,
    input  logic                      fr_rise,
    input  logic                      fr_fall,
    input  logic                      sel_chg,
    input  logic [LANES-1:0]          bit_dat,
    output logic [LANES-1:0][W-1:0]   left_o,
    output logic [LANES-1:0][W-1:0]   right_o,
    output logic                      valid_o,
    output logic                      rate_err_o
);
    localparam int HCW = $clog2(W + 1);
    localparam int FCW = $clog2(HI_BCK) + 1;

    fr_state_e       st, st_nx;
    logic [HCW-1:0]  hcnt;
    logic [FCW-1:0]  fcnt;
    logic            start_half, latch_left, frame_end, rate_ok, publish, want_bit;

    // next-state logic: start, split, wrap, abandon
    always_comb begin
        st_nx = st;
        unique case (st)
            S_HUNT:  if (fr_rise) st_nx = S_LEFT;
            S_LEFT:  if (fr_fall) st_nx = S_RIGHT;
            S_RIGHT: if (fr_rise) st_nx = S_LEFT;
            default: st_nx = S_HUNT;
        endcase
        if (sel_chg) st_nx = S_HUNT;  // R7
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_HUNT;
        else        st <= st_nx;
    end

    assign start_half = !sel_chg &&
                        (((st == S_HUNT || st == S_RIGHT) && fr_rise) ||
                         (st == S_LEFT && fr_fall));
    assign latch_left = !sel_chg && (st == S_LEFT) && fr_fall;
    assign frame_end  = !sel_chg && (st == S_RIGHT) && fr_rise;
    assign rate_ok    = (fcnt == FCW'(LO_BCK)) || (fcnt == FCW'(HI_BCK));
    assign publish    = frame_end && rate_ok;
    assign want_bit   = bit_stb && (hcnt < HCW'(W));  // R5: tail bits dropped

    // counters; R8: a coincident bit opens the new half and frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            fcnt <= '0;
        end else if (sel_chg) begin
            hcnt <= '0;
            fcnt <= '0;
        end else if (start_half) begin
            hcnt <= bit_stb ? HCW'(1) : '0;
            if (st != S_LEFT)
                fcnt <= bit_stb ? FCW'(1) : '0;
            else if (bit_stb && fcnt != '1)
                fcnt <= fcnt + 1'b1;
        end else if (st != S_HUNT && bit_stb) begin
            if (want_bit) hcnt <= hcnt + 1'b1;
            if (fcnt != '1) fcnt <= fcnt + 1'b1;
        end
    end

    // output process: strobe and rate flag (R5, R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            rate_err_o <= 1'b0;
        end else begin
            valid_o <= publish;
            if (frame_end) rate_err_o <= !rate_ok;
        end
    end

    // per-lane shifting, left hold and publication (R3, R4)
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W-1:0] sh, held, out_l, out_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh    <= '0;
                held  <= '0;
                out_l <= '0;
                out_r <= '0;
            end else begin
                if (start_half)
                    sh <= bit_stb ? W'(bit_dat[g]) : '0;
                else if (st != S_HUNT && want_bit)
                    sh <= {sh[W-2:0], bit_dat[g]};
                if (latch_left) held <= sh;
                if (publish) begin
                    out_l <= held;
                    out_r <= sh;
                end
            end
        end

        assign left_o[g]  = out_l;
        assign right_o[g] = out_r;
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R6
    valid_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !rate_err_o);
    // R5
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o)));
    // R7
    hunt_on_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (st == S_HUNT));
    // R4
    publish_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (st == S_LEFT));
endmodule

// File: rtl/lj_dual_rx.sv
module lj_dual_rx #(
    parameter int W      = 24,
    parameter int LO_BCK = 64,
    parameter int HI_BCK = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_sel,
    input  logic         dac_bclk,
    input  logic         dac_fclk,
    input  logic         adc_bclk,
    input  logic         adc_fclk,
    input  logic         sdata_a,
    input  logic         sdata_b,
    output logic [W-1:0] left_a,
    output logic [W-1:0] right_a,
    output logic [W-1:0] left_b,
    output logic [W-1:0] right_b,
    output logic         smp_valid,
    output logic         rate_err
);
    localparam int LANES = 2;
    localparam int SW    = 5 + LANES;

    logic [SW-1:0]             raw, syn;
    logic                      bit_stb, fr_rise, fr_fall, sel_chg;
    logic [LANES-1:0]          bit_dat;
    logic [LANES-1:0][W-1:0]   lw, rw;

    assign raw = {src_sel, dac_bclk, dac_fclk, adc_bclk, adc_fclk, sdata_b, sdata_a};

    ljrx_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    ljrx_front #(.LANES(LANES)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (syn[6]),
        .dac_bclk_s (syn[5]),
        .dac_fclk_s (syn[4]),
        .adc_bclk_s (syn[3]),
        .adc_fclk_s (syn[2]),
        .dat_s      (syn[1:0]),
        .bit_stb    (bit_stb),
        .fr_rise    (fr_rise),
        .fr_fall    (fr_fall),
        .sel_chg    (sel_chg),
        .bit_dat    (bit_dat)
    );

    ljrx_frame #(.W(W), .LANES(LANES), .LO_BCK(LO_BCK), .HI_BCK(HI_BCK)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb    (bit_stb),
        .fr_rise    (fr_rise),
        .fr_fall    (fr_fall),
        .sel_chg    (sel_chg),
        .bit_dat    (bit_dat),
        .left_o     (lw),
        .right_o    (rw),
        .valid_o    (smp_valid),
        .rate_err_o (rate_err)
    );

    assign left_a  = lw[0];
    assign right_a = rw[0];
    assign left_b  = lw[1];
    assign right_b = rw[1];
endmodule

// File: tb/tb_lj_dual_rx.sv
module tb_lj_dual_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic src_sel = 1'b0;
    logic [1:0] bclk_v = 2'b00;   // [1] DAC-side, [0] ADC-side
    logic [1:0] fclk_v = 2'b00;
    logic sda = 1'b0, sdb = 1'b0;
    logic [23:0] left_a, right_a, left_b, right_b;
    logic smp_valid, rate_err;

    int n_chk = 0, n_fail = 0, vcnt = 0;
    logic [95:0] cap = '0;

    always #5 clk = ~clk;

    lj_dual_rx dut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .dac_bclk(bclk_v[1]), .dac_fclk(fclk_v[1]),
        .adc_bclk(bclk_v[0]), .adc_fclk(fclk_v[0]),
        .sdata_a(sda), .sdata_b(sdb),
        .left_a(left_a), .right_a(right_a), .left_b(left_b), .right_b(right_b),
        .smp_valid(smp_valid), .rate_err(rate_err)
    );

    always @(negedge clk) if (rst_n && smp_valid) begin
        vcnt++;
        cap = {left_a, right_a, left_b, right_b};
    end

    // {pair, bits per frame, coincident edges, la, ra, lb, rb}
    localparam logic [105:0] VEC [0:5] = '{
        {1'b0, 8'd64,  1'b0, 24'h123456, 24'hABCDEF, 24'h800001, 24'h7FFFFE},
        {1'b1, 8'd64,  1'b0, 24'hFFFFFF, 24'h000000, 24'hA5A5A5, 24'h5A5A5A},
        {1'b1, 8'd128, 1'b0, 24'h0F0F0F, 24'hF0F0F0, 24'h13579B, 24'h2468AC},
        {1'b0, 8'd128, 1'b0, 24'h800000, 24'h000001, 24'hFEDCBA, 24'h654321},
        {1'b0, 8'd64,  1'b1, 24'hC3C3C3, 24'h3C3C3C, 24'h111111, 24'hEEEEEE},
        {1'b1, 8'd128, 1'b1, 24'h00FF00, 24'hFF00FF, 24'h987654, 24'h456789}
    };
    localparam logic [95:0] FLUSH = {24'h5A5A5A, 24'hC0FFEE, 24'h0BADF0, 24'h777777};

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_frame(input int p, input int nb, input logic [95:0] w,
                              input bit coinc, input int stop);
        for (int i = 0; i < nb; i++) begin
            bit hi;
            int j;
            logic [23:0] wa, wb;
            if (i >= stop) return;
            hi = (i < nb / 2);
            j  = hi ? i : i - nb / 2;
            wa = hi ? w[95:72] : w[71:48];
            wb = hi ? w[47:24] : w[23:0];
            if (j == 0 && !coinc) fclk_v[p] = hi;
            sda = (j < 24) ? wa[23-j] : 1'b1;
            sdb = (j < 24) ? wb[23-j] : 1'b1;
            #40;
            if (j == 0 && coinc) fclk_v[p] = hi;
            bclk_v[p] = 1'b1;
            #40;
            bclk_v[p] = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 words in reset", {left_a, right_a, left_b, right_b}, '0);
        chk("R1 flags in reset", {94'd0, smp_valid, rate_err}, '0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 after release", {left_a, right_a, left_b, right_b, 2'b00} | {96'd0, smp_valid, rate_err}, '0);

        // vector walk: R2 pair, R3/R4 bit order, R5 rate, R8 coincidence
        for (int v = 0; v < 6; v++) begin
            logic [105:0] e;
            e = VEC[v];
            @(negedge clk);
            src_sel = e[105];
            repeat (6) @(negedge clk);
            send_frame(int'(e[105]), int'(e[104:97]), e[95:0], e[96], 1000);
            send_frame(int'(e[105]), int'(e[104:97]), FLUSH, 1'b0, 1000);
            chk(e[96] ? "R8 coincident frame words" :
                (e[105] ? "R2 R3 R4 R5 dac pair words" : "R2 R3 R4 R5 adc pair words"),
                cap, e[95:0]);
        end

        // R6: illegal bit count
        @(negedge clk);
        src_sel = 1'b0;
        repeat (6) @(negedge clk);
        send_frame(0, 64, VEC[0][95:0], 1'b0, 1000);
        send_frame(0, 96, VEC[1][95:0], 1'b0, 1000);
        c = vcnt;
        send_frame(0, 64, VEC[3][95:0], 1'b0, 1000);
        chk("R6 flag set", {95'd0, rate_err}, 96'd1);
        chk("R6 no pulse", 96'(vcnt), 96'(c));
        chk("R6 words held", {left_a, right_a, left_b, right_b}, VEC[0][95:0]);
        send_frame(0, 64, FLUSH, 1'b0, 1000);
        chk("R6 flag cleared", {95'd0, rate_err}, 96'd0);
        chk("R6 recovery words", cap, VEC[3][95:0]);

        // R7: select change in mid-frame
        send_frame(0, 64, VEC[2][95:0], 1'b0, 1000);
        send_frame(0, 64, VEC[4][95:0], 1'b0, 40);
        c = vcnt;
        @(negedge clk);
        src_sel = 1'b1;
        fclk_v[0] = 1'b0;
        repeat (6) @(negedge clk);
        send_frame(1, 128, VEC[5][95:0], 1'b0, 1000);
        send_frame(1, 128, FLUSH, 1'b0, 1000);
        chk("R7 one pulse after switch", 96'(vcnt), 96'(c + 1));
        chk("R7 words from new pair", cap, VEC[5][95:0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule